// File: doc/BRIEF.md
# Serial Byte-Memory Slave Front End

This block is the serial slave side of a byte-wide nonvolatile-style memory with 256K locations. A host selects it with an active-low chip select and clocks commands in on a serial clock in SPI mode 0 or mode 3. The first byte of every select period is the command. A read or write command is followed by a three-byte address, sent most significant bit first. Only the low 18 bits of that address are kept. Read data goes out on a serial output with a separate drive enable. Each received write byte goes to the array as soon as its eighth bit has arrived, so the host never waits or polls.

All pins are brought into the system clock domain by synchronizers, and the block acts on edges it detects there. It keeps the write-enable latch itself. The protection policy sits in a neighbouring block, which grants array writes and status writes through two permission inputs. That block owns the status byte, and this block returns it on a status read and hands it the new value on a status write. The storage array sits outside the block as a synchronous RAM with one cycle of read latency. A low level on the hold input freezes the transfer, and the frozen transfer picks up again where it stopped.

The controller has these states:
- `ST_IDLE`: the chip is deselected.
- `ST_OPCODE`: the command byte is arriving.
- `ST_ADDR`: the three address bytes are arriving.
- `ST_WDATA`: array write data is arriving.
- `ST_RDATA`: array read data is going out.
- `ST_SRD`: the status byte is going out.
- `ST_SWR`: a status byte is arriving.
- `ST_DISCARD`: every further bit is ignored.

The transitions are:
- select falling: `ST_IDLE`→`ST_OPCODE`.
- command complete: `ST_OPCODE`→`ST_ADDR`, `ST_SRD`, `ST_SWR` or `ST_DISCARD`, depending on the command.
- address complete: `ST_ADDR`→`ST_WDATA` or `ST_RDATA`.
- status byte complete: `ST_SWR`→`ST_DISCARD`.
- select rising: any state→`ST_IDLE`.

Top module: `spi_mem_front`

## Requirements
- R1: After reset the output enable is low, the write-enable latch reads 0, and no array or status write pulse occurs.
- R2: The first 8 bits after a falling select, taken most significant bit first, form the command. Only one command is accepted per select period. A command byte sent later in the same period has no effect on the latch.
- R3: Command 0x06 sets the latch and 0x04 clears it, both visible on `wel_o`. The latch also clears when the select period of a 0x02 or 0x01 command ends.
- R4: After command 0x03 (read) or 0x02 (write), the next 24 bits are the address, sent most significant bit first. The top 6 bits are ignored and the low 18 bits select the byte.
- R5: In a write, each complete data byte produces a one-cycle `mem_we_o` pulse only when the latch is set and `arr_wr_allow_i` is high. The address steps by one after every byte and wraps from 0x3FFFF to 0x00000.
- R6: In a read, array bytes are shifted out most significant bit first. Each bit changes after a falling serial-clock edge. Consecutive locations follow, with the same wrap as R5.
- R7: Command 0x05 shifts out `stat_i` repeatedly. Command 0x01 takes the next byte and pulses `stat_we_o` with that byte only when the latch is set and `stat_wr_allow_i` is high.
- R8: An unknown command is discarded. The output enable stays low, no write happens and the latch keeps its value until select rises.
- R9: `so_oe_o` is high only during the data phase of 0x03 or 0x05 while selected with hold released. It is low in every other case.
- R10: While hold is low, serial-clock and select edges are ignored and the output enable is low. When hold returns high, the transfer continues from the same bit.
- R11: If select rises in the middle of a data byte, the transfer is cancelled and that partial byte is never written.
- R12: Both idle clock levels work, low (mode 0) and high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Active-low hold |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for the serial output pad |
| wel_o | output | 1 | Write-enable latch state |
| stat_i | input | 8 | Status byte returned by command 0x05 |
| stat_wr_allow_i | input | 1 | Permission for a status write |
| stat_we_o | output | 1 | Status write pulse |
| stat_wdata_o | output | 8 | New status byte |
| arr_wr_allow_i | input | 1 | Permission for array writes at the current address |
| mem_we_o | output | 1 | Array write pulse |
| mem_addr_o | output | 18 | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one cycle after the address |

## Verification
On every cycle the assertions check the following:
- The output enable never rises while the chip is deselected or a command is being discarded.
- A hold freezes both the state and the address counter.
- Array write pulses last one cycle and come only out of the write-data phase.
- Status write pulses follow a set latch.

Only the bench's scenarios can show the rest. This covers bit order and address truncation, and the wrap at the top of the array. It also covers cancellation of a partial byte, that a second command in one select period is ignored, that the latch clears at the end of a frame, and that a transfer resumes intact after a hold with select toggling.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SRD,
        ST_SWR,
        ST_DISCARD
    } ctl_state_e;

    localparam logic [7:0] CMD_LATCH_SET  = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR  = 8'h04;
    localparam logic [7:0] CMD_STAT_READ  = 8'h05;
    localparam logic [7:0] CMD_STAT_WRITE = 8'h01;
    localparam logic [7:0] CMD_ARR_READ   = 8'h03;
    localparam logic [7:0] CMD_ARR_WRITE  = 8'h02;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic si_i,
    input  logic holdn_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_active,
    output logic si_bit,
    output logic hold_ok
);

    localparam int PINS = 4;
    localparam int CW   = SYNC_STAGES * PINS;
    // {holdn, si, csn, sck}
    localparam logic [PINS-1:0] PIN_RST = 4'b1010;

    logic [PINS-1:0] raw_pins;
    logic [PINS-1:0] synced;
    logic [CW-1:0]   chain_q;
    logic            sck_q;
    logic            csn_eff_q;
    logic            csn_seen_q;

    assign raw_pins = {holdn_i, si_i, csn_i, sck_i};

    generate
        if (SYNC_STAGES == 1) begin : g_one_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= PIN_RST;
                else        chain_q <= raw_pins;
            end
        end else begin : g_multi_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {SYNC_STAGES{PIN_RST}};
                else        chain_q <= {chain_q[CW-PINS-1:0], raw_pins};
            end
        end
    endgenerate

    assign synced  = chain_q[CW-1 -: PINS];
    assign hold_ok = synced[3];
    assign si_bit  = synced[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            csn_eff_q  <= 1'b1;
            csn_seen_q <= 1'b1;
        end else begin
            sck_q <= synced[0];
            if (hold_ok) begin
                csn_eff_q  <= synced[1];
                csn_seen_q <= csn_eff_q;
            end
        end
    end

    assign sck_rise  = hold_ok &  synced[0] & ~sck_q;
    assign sck_fall  = hold_ok & ~synced[0] &  sck_q;
    assign cs_start  = hold_ok &  csn_seen_q & ~csn_eff_q;
    assign cs_end    = hold_ok & ~csn_seen_q &  csn_eff_q;
    assign cs_active = ~csn_eff_q;

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              cs_active,
    input  logic              si_bit,
    input  logic              hold_ok,
    input  logic [7:0]        stat_i,
    input  logic              stat_wr_allow_i,
    input  logic              arr_wr_allow_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              wel_o,
    output logic              stat_we_o,
    output logic [7:0]        stat_wdata_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);

    localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ABW-1:0] ABYTE_LAST = ABW'(ADDR_BYTES - 1);

    ctl_state_e        state_q, state_d;
    logic [2:0]        bit_q;
    logic [7:0]        sh_q;
    logic [ABW-1:0]    abyte_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wa_q;
    logic [7:0]        wd_q;
    logic              is_wr_q;
    logic              wel_q;
    logic              clr_pend_q;
    logic [7:0]        osh_q;
    logic              so_q;
    logic              mem_we_q;
    logic              stat_we_q;
    logic [7:0]        stat_wd_q;

    logic       last_bit;
    logic [7:0] byte_in;
    logic [7:0] out_src;
    logic       shifting;
    logic       reading;

    assign last_bit = (bit_q == 3'd7);
    assign byte_in  = {sh_q[6:0], si_bit};
    assign reading  = (state_q == ST_RDATA) || (state_q == ST_SRD);
    assign out_src  = (state_q == ST_SRD) ? stat_i : mem_rdata_i;
    assign shifting = (state_q != ST_IDLE) && (state_q != ST_DISCARD);

    function automatic ctl_state_e cmd_target(input logic [7:0] cmd);
        unique case (cmd)
            CMD_ARR_READ, CMD_ARR_WRITE: cmd_target = ST_ADDR;
            CMD_STAT_READ:               cmd_target = ST_SRD;
            CMD_STAT_WRITE:              cmd_target = ST_SWR;
            default:                     cmd_target = ST_DISCARD;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_end) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (cs_start) state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && last_bit) state_d = cmd_target(byte_in);
                ST_ADDR:   if (sck_rise && last_bit && abyte_q == ABYTE_LAST)
                               state_d = is_wr_q ? ST_WDATA : ST_RDATA;
                ST_SWR:    if (sck_rise && last_bit) state_d = ST_DISCARD;
                default:   state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= 3'd0;
            sh_q       <= 8'd0;
            abyte_q    <= '0;
            addr_q     <= '0;
            wa_q       <= '0;
            wd_q       <= 8'd0;
            is_wr_q    <= 1'b0;
            wel_q      <= 1'b0;
            clr_pend_q <= 1'b0;
            osh_q      <= 8'd0;
            so_q       <= 1'b0;
            mem_we_q   <= 1'b0;
            stat_we_q  <= 1'b0;
            stat_wd_q  <= 8'd0;
        end else begin
            mem_we_q  <= 1'b0;
            stat_we_q <= 1'b0;
            if (cs_start) begin
                bit_q   <= 3'd0;
                abyte_q <= '0;
            end
            if (cs_end) begin
                bit_q   <= 3'd0;
                abyte_q <= '0;
                if (clr_pend_q) begin
                    wel_q      <= 1'b0;
                    clr_pend_q <= 1'b0;
                end
            end else if (sck_rise && shifting) begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= byte_in;
                if (state_q == ST_ADDR) addr_q <= {addr_q[ADDR_W-2:0], si_bit};
                if (last_bit) begin
                    unique case (state_q)
                        ST_OPCODE: begin
                            if (byte_in == CMD_LATCH_SET) wel_q <= 1'b1;
                            if (byte_in == CMD_LATCH_CLR) wel_q <= 1'b0;
                            is_wr_q <= (byte_in == CMD_ARR_WRITE);
                            if (byte_in == CMD_ARR_WRITE || byte_in == CMD_STAT_WRITE)
                                clr_pend_q <= 1'b1;
                        end
                        ST_ADDR: abyte_q <= abyte_q + 1'b1;
                        ST_WDATA: begin
                            if (wel_q && arr_wr_allow_i) begin
                                mem_we_q <= 1'b1;
                                wa_q     <= addr_q;
                                wd_q     <= byte_in;
                            end
                            addr_q <= addr_q + 1'b1;
                        end
                        ST_RDATA: addr_q <= addr_q + 1'b1;
                        ST_SWR: begin
                            if (wel_q && stat_wr_allow_i) begin
                                stat_we_q <= 1'b1;
                                stat_wd_q <= byte_in;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall && reading) begin
                if (bit_q == 3'd0) begin
                    so_q  <= out_src[7];
                    osh_q <= {out_src[6:0], 1'b0};
                end else begin
                    so_q  <= osh_q[7];
                    osh_q <= {osh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign so_o         = so_q;
    assign so_oe_o      = cs_active && hold_ok && reading;
    assign wel_o        = wel_q;
    assign stat_we_o    = stat_we_q;
    assign stat_wdata_o = stat_wd_q;
    assign mem_we_o     = mem_we_q;
    assign mem_addr_o   = mem_we_q ? wa_q : addr_q;
    assign mem_wdata_o  = wd_q;

    // R9
    oe_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !so_oe_o);

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ok |=> ($stable(state_q) && $stable(addr_q)));

    // R5
    write_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R5
    write_from_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($past(state_q) == ST_WDATA));

    // R8
    discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |-> (!so_oe_o && !mem_we_o));

    // R7
    status_write_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_o |-> $past(wel_q));

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
    parameter int ADDR_W      = 18,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              si_i,
    input  logic              holdn_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              wel_o,
    input  logic [7:0]        stat_i,
    input  logic              stat_wr_allow_i,
    output logic              stat_we_o,
    output logic [7:0]        stat_wdata_o,
    input  logic              arr_wr_allow_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);

    logic sck_rise, sck_fall, cs_start, cs_end, cs_active, si_bit, hold_ok;

    spi_mem_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck_i),
        .csn_i     (csn_i),
        .si_i      (si_i),
        .holdn_i   (holdn_i),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .cs_active (cs_active),
        .si_bit    (si_bit),
        .hold_ok   (hold_ok)
    );

    spi_mem_ctrl #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .sck_rise        (sck_rise),
        .sck_fall        (sck_fall),
        .cs_start        (cs_start),
        .cs_end          (cs_end),
        .cs_active       (cs_active),
        .si_bit          (si_bit),
        .hold_ok         (hold_ok),
        .stat_i          (stat_i),
        .stat_wr_allow_i (stat_wr_allow_i),
        .arr_wr_allow_i  (arr_wr_allow_i),
        .mem_rdata_i     (mem_rdata_i),
        .so_o            (so_o),
        .so_oe_o         (so_oe_o),
        .wel_o           (wel_o),
        .stat_we_o       (stat_we_o),
        .stat_wdata_o    (stat_wdata_o),
        .mem_we_o        (mem_we_o),
        .mem_addr_o      (mem_addr_o),
        .mem_wdata_o     (mem_wdata_o)
    );

endmodule

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb_top;

    localparam int HP = 8;
    localparam int WATCHDOG = 190000;
    localparam logic [17:0] AMASK = 18'h3FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn = 1'b1, si = 1'b0, holdn = 1'b1;
    logic [7:0] stat_val = 8'h00;
    logic swr_ok = 1'b1, arr_ok = 1'b1;
    logic so, so_oe, wel, stat_we, mem_we;
    logic [7:0] stat_wd, mem_wd;
    logic [7:0] mem_rd = 8'h00;
    logic [17:0] mem_a;

    always #10 clk = ~clk;

    spi_mem_front dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si), .holdn_i(holdn),
        .so_o(so), .so_oe_o(so_oe), .wel_o(wel), .stat_i(stat_val),
        .stat_wr_allow_i(swr_ok), .stat_we_o(stat_we), .stat_wdata_o(stat_wd),
        .arr_wr_allow_i(arr_ok), .mem_we_o(mem_we), .mem_addr_o(mem_a),
        .mem_wdata_o(mem_wd), .mem_rdata_i(mem_rd)
    );

    logic [7:0] bmem [int];
    logic [7:0] ref_mem [int];
    int we_cnt = 0, swe_cnt = 0;
    logic [7:0] last_swd = 8'h00;
    bit oe_seen = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit mode3 = 1'b0;
    bit done = 1'b0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always @(posedge clk) begin
        mem_rd <= bmem.exists(int'(mem_a)) ? bmem[int'(mem_a)] : 8'h00;
        if (mem_we) begin
            bmem[int'(mem_a)] = mem_wd;
            we_cnt++;
        end
        if (stat_we) begin
            swe_cnt++;
            last_swd = stat_wd;
        end
        if (so_oe) oe_seen = 1'b1;
    end

    function automatic logic [7:0] ref_rd(input logic [17:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        sck = mode3;
        tick(HP);
        csn = 1'b0;
        tick(HP);
    endtask

    task automatic frame_end();
        if (!mode3) sck = 1'b0;
        tick(HP);
        csn = 1'b1;
        tick(2 * HP);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input bit with_hold, input bit cs_wiggle);
        for (int b = 7; b >= 0; b--) begin
            sck = 1'b0;
            si  = tx[b];
            tick(HP);
            if (with_hold && b == 3) begin
                holdn = 1'b0;
                tick(HP);
                // R10 output enable dropped while held
                chk("R10 oe during hold", {31'd0, so_oe}, 32'd0);
                for (int k = 0; k < 3; k++) begin
                    si = ~si; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
                end
                if (cs_wiggle) begin
                    csn = 1'b1; tick(HP); csn = 1'b0; tick(HP);
                end
                si = tx[b];
                holdn = 1'b1;
                tick(HP);
            end
            rx[b] = so;
            sck = 1'b1;
            tick(HP);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xbyte(tx, dummy, 1'b0, 1'b0);
    endtask

    task automatic cmd1(input logic [7:0] op);
        frame_begin();
        send(op);
        frame_end();
    endtask

    task automatic send_addr(input logic [23:0] a);
        send(a[23:16]); send(a[15:8]); send(a[7:0]);
    endtask

    task automatic do_write(input logic [23:0] a, input int n, input bit commit);
        frame_begin();
        send(8'h02);
        send_addr(a);
        for (int i = 0; i < n; i++) send(wbuf[i]);
        frame_end();
        if (commit)
            for (int i = 0; i < n; i++) ref_mem[int'((a[17:0] + 18'(i)) & AMASK)] = wbuf[i];
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input int hold_at);
        logic [7:0] r;
        frame_begin();
        send(8'h03);
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, (i == hold_at), 1'b0);
            rbuf[i] = r;
        end
        frame_end();
    endtask

    task automatic check_read(input logic [23:0] a, input int n, input string req);
        do_read(a, n, -1);
        for (int i = 0; i < n; i++)
            chk(req, {24'd0, rbuf[i]}, {24'd0, ref_rd((a[17:0] + 18'(i)) & AMASK)});
    endtask

    initial begin
        int w0;
        logic [7:0] r;
        void'($urandom(32'd20240611));
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        chk("R1 oe", {31'd0, so_oe}, 32'd0);
        chk("R1 latch", {31'd0, wel}, 32'd0);
        chk("R1 writes", we_cnt, 0);

        // R3 latch set and clear
        cmd1(8'h06);
        chk("R3 set", {31'd0, wel}, 32'd1);
        cmd1(8'h04);
        chk("R3 clear", {31'd0, wel}, 32'd0);

        // R5 no write without latch
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        w0 = we_cnt;
        do_write(24'h000200, 2, 1'b0);
        chk("R5 no latch", we_cnt - w0, 0);

        // R4 top address bits ignored, R5 burst, R3 clear at frame end
        cmd1(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i * 17);
        w0 = we_cnt;
        do_write(24'hFC0010, 4, 1'b1);
        chk("R5 count", we_cnt - w0, 4);
        chk("R3 auto clear", {31'd0, wel}, 32'd0);
        check_read(24'h000010, 4, "R4 R6 readback");

        // R5 R6 wrap at top of array
        cmd1(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
        do_write(24'h03FFFE, 4, 1'b1);
        chk("R5 wrap low", {24'd0, ref_rd(18'h00001)}, 32'hE3);
        check_read(24'h03FFFF, 3, "R6 wrap read");

        // R5 permission withheld
        arr_ok = 1'b0;
        cmd1(8'h06);
        wbuf[0] = 8'h99;
        w0 = we_cnt;
        do_write(24'h000010, 1, 1'b0);
        chk("R5 no permission", we_cnt - w0, 0);
        arr_ok = 1'b1;
        check_read(24'h000010, 1, "R5 unchanged");

        // R7 status read, R9 enable seen
        stat_val = 8'hA5;
        oe_seen = 1'b0;
        frame_begin();
        send(8'h05);
        xbyte(8'h00, r, 1'b0, 1'b0); chk("R7 status byte0", {24'd0, r}, 32'hA5);
        xbyte(8'h00, r, 1'b0, 1'b0); chk("R7 status byte1", {24'd0, r}, 32'hA5);
        frame_end();
        chk("R9 oe in read", {31'd0, oe_seen}, 32'd1);
        chk("R9 oe after frame", {31'd0, so_oe}, 32'd0);

        // R7 status write
        cmd1(8'h06);
        w0 = swe_cnt;
        frame_begin(); send(8'h01); send(8'h3C); send(8'h77); frame_end();
        chk("R7 status write count", swe_cnt - w0, 1);
        chk("R7 status write data", {24'd0, last_swd}, 32'h3C);
        chk("R3 clear after status write", {31'd0, wel}, 32'd0);
        w0 = swe_cnt;
        frame_begin(); send(8'h01); send(8'h11); frame_end();
        chk("R7 status write no latch", swe_cnt - w0, 0);
        swr_ok = 1'b0;
        cmd1(8'h06);
        frame_begin(); send(8'h01); send(8'h22); frame_end();
        chk("R7 status write no permission", swe_cnt - w0, 0);
        swr_ok = 1'b1;

        // R8 invalid command discarded
        cmd1(8'h06);
        oe_seen = 1'b0;
        w0 = we_cnt;
        frame_begin(); send(8'h0B); send(8'h02); send_addr(24'h000010); send(8'h44); send(8'h03); frame_end();
        chk("R8 no oe", {31'd0, oe_seen}, 32'd0);
        chk("R8 no write", we_cnt - w0, 0);
        chk("R8 latch kept", {31'd0, wel}, 32'd1);

        // R2 one command per frame
        frame_begin(); send(8'h06); send(8'h04); frame_end();
        chk("R2 second cmd ignored", {31'd0, wel}, 32'd1);

        // R9 no enable during write frame
        oe_seen = 1'b0;
        wbuf[0] = 8'h6E;
        do_write(24'h000020, 1, 1'b1);
        chk("R9 no oe in write", {31'd0, oe_seen}, 32'd0);

        // R11 abort mid byte
        cmd1(8'h06);
        w0 = we_cnt;
        frame_begin();
        send(8'h02); send_addr(24'h000100); send(8'h11);
        for (int b = 7; b >= 4; b--) begin
            sck = 1'b0; si = 1'b1; tick(HP); sck = 1'b1; tick(HP);
        end
        frame_end();
        ref_mem[32'h100] = 8'h11;
        chk("R11 one write", we_cnt - w0, 1);
        check_read(24'h000100, 2, "R11 partial not written");

        // R10 hold during read and during write with select toggling
        do_read(24'h000010, 3, 1);
        for (int i = 0; i < 3; i++)
            chk("R10 read across hold", {24'd0, rbuf[i]}, {24'd0, ref_rd(18'h00010 + 18'(i))});
        cmd1(8'h06);
        frame_begin();
        send(8'h02); send_addr(24'h000300);
        xbyte(8'hB7, r, 1'b1, 1'b1);
        send(8'h4D);
        frame_end();
        ref_mem[32'h300] = 8'hB7; ref_mem[32'h301] = 8'h4D;
        check_read(24'h000300, 2, "R10 write across hold");

        // R12 mode 3 directed
        mode3 = 1'b1;
        cmd1(8'h06);
        chk("R12 mode3 latch", {31'd0, wel}, 32'd1);
        wbuf[0] = 8'h81; wbuf[1] = 8'h7E;
        do_write(24'h001234, 2, 1'b1);
        check_read(24'h001234, 2, "R12 mode3 readback");

        // R5 R6 R12 random traffic
        for (int t = 0; t < 14; t++) begin
            logic [23:0] a;
            int n;
            mode3 = 1'($urandom % 2);
            a = 24'($urandom);
            if (t % 4 == 0) a[17:0] = 18'h3FFFC;
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            cmd1(8'h06);
            do_write(a, n, 1'b1);
            check_read(a, n, "R5 R6 R12 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule